// File: doc/BRIEF.md
# Pipeline Front End: PC Update and Instruction Fetch

This block is the first two stages of a five-stage 32-bit pipeline. It holds the program counter and a small word-addressed instruction store. Each clock it chooses the next PC and the next word for the fetch/decode instruction register. It takes a stall request and a taken-branch flag with a signed 32-bit offset. Both come from hazard and branch logic further down the pipe.

The two stages resolve a stall and a branch that arrive together in opposite orders. The PC stage lets the stall win, so the PC holds. The fetch stage lets the branch win, so the instruction register is squashed to a nop. A bubble is inserted while the PC stays put.

The instruction store is filled through a word-indexed write port. That port only takes effect while reset is asserted. Reset is active-low and asynchronous.

Top module: `pipe_front`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and ifid_ir_o is the nop word 32'h0000_0000.
- R2: With stall_i low and br_taken_i low, pc_o advances by 4 on each rising clock edge.
- R3: With stall_i high and br_taken_i low, pc_o keeps its value across the edge.
- R4: With stall_i low and br_taken_i high, pc_o becomes pc_o plus br_offset_i, added modulo 2^32.
- R5: With stall_i and br_taken_i both high, pc_o keeps its value, because stall has priority in the PC stage.
- R6: With both control inputs low, ifid_ir_o loads the stored word at index (pc_o >> 2) taken from the PC value before the edge.
- R7: With br_taken_i high, ifid_ir_o loads the nop word 32'h0000_0000, whatever stall_i is.
- R8: With stall_i high and br_taken_i low, ifid_ir_o keeps its value.
- R9: A write on ld_we_i stores ld_data_i at word ld_idx_i only while rst_ni is low. Writes made while rst_ni is high leave the store unchanged.
- R10: The store holds 32 words. The fetch index is (pc_o >> 2) modulo 32, so a PC of 128 or more wraps onto the low words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset; also enables the load port |
| stall_i | input | 1 | Hold request from hazard logic |
| br_taken_i | input | 1 | Branch resolved as taken |
| br_offset_i | input | 32 | Byte offset added to the PC on a taken branch |
| ld_we_i | input | 1 | Instruction store write enable, effective only in reset |
| ld_idx_i | input | 5 | Word index for the store write |
| ld_data_i | input | 32 | Word written into the store |
| pc_o | output | 32 | Current program counter |
| ifid_ir_o | output | 32 | Fetch/decode instruction register |

## Verification
The main loop drives a fixed sequence of control patterns. These are plain sequential flow, a stall alone, a taken branch alone, and stall with branch together. It also includes negative and large branch offsets. Every word in the store has a distinct nonzero value. A wrong fetch index, a hold that should have been a squash, or a squash that should have been a hold therefore shows up as a different value on ifid_ir_o.

The stall-with-branch pattern separates the two priority orders. The PC must hold while the register shows nop. A large offset moves the PC past 128 to show that the index wraps. A store write attempted outside reset is followed by a fresh reset and a sequential refetch of the target word, which shows that the write was ignored.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned DEPTH = 32;
  localparam logic [XLEN-1:0] NOP_WORD = '0;
  localparam logic [XLEN-1:0] PC_STEP  = XLEN'(4);

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    PC_SEQ  = 2'd0,
    PC_HOLD = 2'd1,
    PC_JUMP = 2'd2
  } pc_sel_e;

  typedef enum logic [1:0] {
    IR_LOAD   = 2'd0,
    IR_HOLD   = 2'd1,
    IR_SQUASH = 2'd2
  } ir_sel_e;
endpackage

// File: rtl/fe_imem.sv
module fe_imem #(
  parameter int unsigned XLEN  = fe_pkg::XLEN,
  parameter int unsigned DEPTH = fe_pkg::DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [XLEN-1:0]  rdata_o
);
  logic [XLEN-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/fe_pc_stage.sv
module fe_pc_stage
  import fe_pkg::*;
#(
  parameter int unsigned XLEN = fe_pkg::XLEN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            br_taken_i,
  input  logic [XLEN-1:0] br_offset_i,
  output logic [XLEN-1:0] pc_o
);
  pc_sel_e         sel;
  logic [XLEN-1:0] pc_q, pc_d;

  // stall outranks branch here
  always_comb begin
    if (stall_i)         sel = PC_HOLD;
    else if (br_taken_i) sel = PC_JUMP;
    else                 sel = PC_SEQ;
  end

  always_comb begin
    unique case (sel)
      PC_HOLD: pc_d = pc_q;
      PC_JUMP: pc_d = pc_q + br_offset_i;
      default: pc_d = pc_q + XLEN'(PC_STEP);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fe_fetch_stage.sv
module fe_fetch_stage
  import fe_pkg::*;
#(
  parameter int unsigned XLEN = fe_pkg::XLEN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            br_taken_i,
  input  logic [XLEN-1:0] fetch_word_i,
  output logic [XLEN-1:0] ir_o
);
  ir_sel_e         sel;
  logic [XLEN-1:0] ir_q, ir_d;

  // branch squash outranks stall here
  always_comb begin
    if (br_taken_i)   sel = IR_SQUASH;
    else if (stall_i) sel = IR_HOLD;
    else              sel = IR_LOAD;
  end

  always_comb begin
    unique case (sel)
      IR_SQUASH: ir_d = XLEN'(NOP_WORD);
      IR_HOLD:   ir_d = ir_q;
      default:   ir_d = fetch_word_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ir_q <= XLEN'(NOP_WORD);
    else         ir_q <= ir_d;
  end

  assign ir_o = ir_q;
endmodule

// File: rtl/pipe_front.sv
module pipe_front
  import fe_pkg::*;
#(
  parameter int unsigned XLEN  = fe_pkg::XLEN,
  parameter int unsigned DEPTH = fe_pkg::DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic             br_taken_i,
  input  logic [XLEN-1:0]  br_offset_i,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [XLEN-1:0]  ld_data_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  ifid_ir_o
);
  logic [XLEN-1:0]  pc;
  logic [XLEN-1:0]  fetch_word;
  logic [IDX_W-1:0] fetch_idx;
  logic             load_en;

  // loading is only legal while the pipe is held in reset
  assign load_en   = ld_we_i & ~rst_ni;
  assign fetch_idx = IDX_W'(pc >> 2);

  fe_pc_stage #(.XLEN(XLEN)) u_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .br_taken_i  (br_taken_i),
    .br_offset_i (br_offset_i),
    .pc_o        (pc)
  );

  fe_imem #(.XLEN(XLEN), .DEPTH(DEPTH)) u_imem (
    .clk_i   (clk_i),
    .we_i    (load_en),
    .widx_i  (ld_idx_i),
    .wdata_i (ld_data_i),
    .ridx_i  (fetch_idx),
    .rdata_o (fetch_word)
  );

  fe_fetch_stage #(.XLEN(XLEN)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall_i),
    .br_taken_i   (br_taken_i),
    .fetch_word_i (fetch_word),
    .ir_o         (ifid_ir_o)
  );

  assign pc_o = pc;
endmodule

// File: rtl/pipe_front_chk.sv
module pipe_front_chk #(
  parameter int unsigned XLEN = fe_pkg::XLEN
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic            br_taken_i,
  input logic [XLEN-1:0] br_offset_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] ifid_ir_o
);
  p_seq_pc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !br_taken_i) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  p_hold_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !br_taken_i) |=> $stable(pc_o));

  p_jump_pc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && br_taken_i) |=> (pc_o == $past(pc_o) + $past(br_offset_i)));

  p_stall_wins_pc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && br_taken_i) |=> $stable(pc_o));

  p_squash_ir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_i |=> (ifid_ir_o == '0));

  p_hold_ir_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !br_taken_i) |=> $stable(ifid_ir_o));
endmodule

bind pipe_front pipe_front_chk #(.XLEN(XLEN)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_i     (stall_i),
  .br_taken_i  (br_taken_i),
  .br_offset_i (br_offset_i),
  .pc_o        (pc_o),
  .ifid_ir_o   (ifid_ir_o)
);

// File: tb/pipe_front_tb_top.sv
module pipe_front_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stall_i = 1'b0;
  logic        br_taken_i = 1'b0;
  logic [31:0] br_offset_i = '0;
  logic        ld_we_i = 1'b0;
  logic [4:0]  ld_idx_i = '0;
  logic [31:0] ld_data_i = '0;
  logic [31:0] pc_o, ifid_ir_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_pc, m_ir;

  // {stall, branch, offset}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'd0},
    {1'b0, 1'b0, 32'd0},
    {1'b0, 1'b0, 32'd0},
    {1'b1, 1'b0, 32'd0},
    {1'b1, 1'b1, 32'd40},
    {1'b0, 1'b0, 32'd0},
    {1'b0, 1'b1, 32'd16},
    {1'b0, 1'b0, 32'd0},
    {1'b0, 1'b1, 32'hFFFF_FFF8},
    {1'b0, 1'b0, 32'd0},
    {1'b1, 1'b0, 32'd0},
    {1'b0, 1'b1, 32'd200},
    {1'b0, 1'b0, 32'd0},
    {1'b0, 1'b0, 32'd0}
  };

  pipe_front dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .br_taken_i  (br_taken_i),
    .br_offset_i (br_offset_i),
    .ld_we_i     (ld_we_i),
    .ld_idx_i    (ld_idx_i),
    .ld_data_i   (ld_data_i),
    .pc_o        (pc_o),
    .ifid_ir_o   (ifid_ir_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic logic [31:0] word_of(int i);
    return 32'h5A00_0011 + 32'(i) * 32'h0001_0003;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic s, logic b, logic [31:0] off, string ir_tag_ovr);
    string pt, it;
    stall_i = s; br_taken_i = b; br_offset_i = off;
    if (s) pt = b ? "R5" : "R3";
    else   pt = b ? "R4" : "R2";
    if (b)      it = "R7";
    else if (s) it = "R8";
    else        it = (m_pc >= 32'd128) ? "R10" : "R6";
    if (ir_tag_ovr != "") it = ir_tag_ovr;
    if (b)      m_ir = 32'h0;
    else if (!s) m_ir = word_of(int'((m_pc >> 2) & 32'd31));
    if (s)      m_pc = m_pc;
    else if (b) m_pc = m_pc + off;
    else        m_pc = m_pc + 32'd4;
    @(negedge clk_i);
    check({pt, " pc"}, pc_o, m_pc);
    check({it, " ir"}, ifid_ir_o, m_ir);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // preload during reset (R9)
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_i);
      ld_we_i = 1'b1; ld_idx_i = 5'(i); ld_data_i = word_of(i);
    end
    @(negedge clk_i);
    ld_we_i = 1'b0;
    check("R1 pc in reset", pc_o, 32'h0);
    check("R1 ir in reset", ifid_ir_o, 32'h0);
    rst_ni = 1'b1;
    m_pc = 0; m_ir = 0;
    #0.5;
    check("R1 pc after release", pc_o, 32'h0);
    check("R1 ir after release", ifid_ir_o, 32'h0);

    for (int v = 0; v < NV; v++)
      step(VEC[v][33], VEC[v][32], VEC[v][31:0], "");

    // write outside reset must be ignored (R9)
    ld_we_i = 1'b1; ld_idx_i = 5'd3; ld_data_i = 32'hDEAD_BEEF;
    step(1'b1, 1'b0, 32'd0, "");
    ld_we_i = 1'b0;
    stall_i = 1'b0; br_taken_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 pc on re-reset", pc_o, 32'h0);
    check("R1 ir on re-reset", ifid_ir_o, 32'h0);
    rst_ni = 1'b1;
    m_pc = 0; m_ir = 0;
    step(1'b0, 1'b0, 32'd0, "");
    step(1'b0, 1'b0, 32'd0, "");
    step(1'b0, 1'b0, 32'd0, "");
    step(1'b0, 1'b0, 32'd0, "R9");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule